// File: doc/BRIEF.md
# Bit-Serial Addressed ALU Node

This block is one processing element in an array of small compute nodes that a central controller drives over a shared two-wire serial bus. One wire carries the bus clock, which the controller drives. The other wire carries data in both directions. Each node has eight strap inputs that fix its bus address. It decodes the command frames addressed to it and runs them against a local set of sixteen 8-bit registers. When asked, it drives a register value back onto the data wire.

All arithmetic and logic is done one bit per core clock, least significant bit first. The operands are taken directly from the register file, with no serial-to-parallel stage in front of a parallel ALU. A single link flop carries the add carry from one bit to the next. The same flop holds the bit shifted out for left shifts and the wrap-around bit for rotates. The finished byte is written back in the eighth cycle, before the node accepts any further frame.

The data wire is brought out as an input, an output and an output enable, so that the tristate pad can sit outside this block. Every bus signal is synchronised into the core clock domain. Bus data is sampled on each rising edge of the bus clock.

Top module: `bsn_node`

## Requirements
- R1: A frame whose 8-bit address field differs from the strap value changes no register and never raises the output enable.
- R2: While the bus is idle, a 0 sampled on a rising bus clock edge is a start bit. The next 24 sampled bits form the frame, LSB first: address in bits 7:0, opcode in bits 11:8, destination index in bits 15:12, source A index in bits 19:16, source B index in bits 23:20.
- R3: Opcode 0 writes (A + B) mod 256 to the destination. The carry flag becomes bit 8 of that sum, and every add starts with a cleared carry.
- R4: Opcode 1 writes {A[6:0],0} and opcode 2 writes {0,A[7:1]}.
- R5: Opcode 3 writes {A[7],A[7:1]} and opcode 4 writes {A[0],A[7:1]}.
- R6: Opcodes 5, 6 and 7 write A AND B, A OR B and A XOR B. Opcode 8 writes NOT A.
- R7: Opcode 9 returns register A on the data wire over 8 bus bit periods, LSB first. Bit 0 is valid from just after the frame's last rising edge, and each following rising edge moves to the next bit. The output enable drops after the 8th rising edge and is otherwise low.
- R8: Opcode 10 returns {7'b0, carry} in the same way. Only opcode 0 changes the carry flag.
- R9: Opcode 11 writes the immediate byte {source B index, source A index} to the destination. Opcodes 12 to 15 write nothing and do not drive the bus.
- R10: After any frame with opcode 9 or 10, whether or not the address matches, the next 8 bus bits are a reply window in which no start bit is recognised.
- R11: After reset, all registers and the carry flag read 0 and the output enable is low.
- R12: When the bus bit period is at least 16 core clocks, a register result, including one whose destination is also a source, is written before the next frame's start bit. That start bit may follow the last frame bit with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| node_addr | input | 8 | Address straps of this node |
| bus_clk_i | input | 1 | Serial bus clock wire |
| bus_dat_i | input | 1 | Serial bus data wire as seen at the pad |
| bus_dat_o | output | 1 | Reply data bit to the pad |
| bus_dat_oe | output | 1 | Pad output enable for the data wire |

## Verification
Most internal faults surface on the wire within a single frame. A wrong link-flop value or bit counter corrupts the byte written back, and the next read of that register shows it about 26 bus bits later. A carry fault shows up on the next status read. A frame decoder that loses bit alignment, for example one that treats a zero in another node's reply as a start bit, fails the next correctly addressed read. In that case either no bits come back or the returned bits are shifted. Enable faults are visible during the reply window itself: the enable is low when a bit is expected, or still high once the window has closed.

// File: rtl/bsn_pkg.sv
package bsn_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int IDX_W   = 4;
  localparam int OP_W    = 4;
  localparam int NREG    = 1 << IDX_W;
  localparam int FRAME_W = ADDR_W + OP_W + 3 * IDX_W;

  localparam logic [OP_W-1:0] OP_ADD  = 4'd0;
  localparam logic [OP_W-1:0] OP_SLL  = 4'd1;
  localparam logic [OP_W-1:0] OP_SRL  = 4'd2;
  localparam logic [OP_W-1:0] OP_SRA  = 4'd3;
  localparam logic [OP_W-1:0] OP_ROR  = 4'd4;
  localparam logic [OP_W-1:0] OP_AND  = 4'd5;
  localparam logic [OP_W-1:0] OP_OR   = 4'd6;
  localparam logic [OP_W-1:0] OP_XOR  = 4'd7;
  localparam logic [OP_W-1:0] OP_NOT  = 4'd8;
  localparam logic [OP_W-1:0] OP_RD   = 4'd9;
  localparam logic [OP_W-1:0] OP_RDST = 4'd10;
  localparam logic [OP_W-1:0] OP_LDI  = 4'd11;

  typedef struct packed {
    logic [IDX_W-1:0]  src_b;
    logic [IDX_W-1:0]  src_a;
    logic [IDX_W-1:0]  dst;
    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] addr;
  } frame_t;
endpackage

// File: rtl/bsn_rx.sv
module bsn_rx
  import bsn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_clk_i,
  input  logic              bus_dat_i,
  input  logic [ADDR_W-1:0] node_addr,
  input  logic              exec_done,
  output frame_t            frame,
  output logic              go_exec,
  output logic              go_read,
  output logic              bit_edge
);
  localparam int CNT_W = $clog2(FRAME_W);

  typedef enum logic [1:0] {RX_IDLE, RX_SHIFT, RX_EXEC, RX_REPLY} rx_state_e;

  rx_state_e          st_q, st_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [FRAME_W-2:0] sh_q, sh_n;
  frame_t             frame_n;
  logic               go_exec_n, go_read_n;
  logic [2:0]         ck_q;
  logic [1:0]         dt_q;
  logic               sd;
  frame_t             full;
  logic               is_rd, is_alu, match;

  // two-stage synchronisers plus an edge stage on the bus clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= '0;
      dt_q <= '1;
    end else begin
      ck_q <= {ck_q[1:0], bus_clk_i};
      dt_q <= {dt_q[0], bus_dat_i};
    end
  end

  assign bit_edge = ck_q[1] & ~ck_q[2];
  assign sd       = dt_q[1];
  assign full     = frame_t'({sd, sh_q});
  assign match    = (full.addr == node_addr);
  assign is_rd    = (full.op == OP_RD) || (full.op == OP_RDST);
  assign is_alu   = (full.op <= OP_NOT) || (full.op == OP_LDI);

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    sh_n      = sh_q;
    frame_n   = frame;
    go_exec_n = 1'b0;
    go_read_n = 1'b0;
    unique case (st_q)
      RX_IDLE: begin
        if (bit_edge && !sd) begin
          st_n  = RX_SHIFT;
          cnt_n = '0;
        end
      end
      RX_SHIFT: begin
        if (bit_edge) begin
          sh_n = {sd, sh_q[FRAME_W-2:1]};
          if (cnt_q == CNT_W'(FRAME_W - 1)) begin
            frame_n = full;
            cnt_n   = '0;
            if (is_rd) begin
              st_n      = RX_REPLY;
              go_read_n = match;
            end else if (match && is_alu) begin
              st_n      = RX_EXEC;
              go_exec_n = 1'b1;
            end else begin
              st_n = RX_IDLE;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      RX_EXEC: begin
        if (exec_done) st_n = RX_IDLE;
      end
      RX_REPLY: begin
        if (bit_edge) begin
          if (cnt_q == CNT_W'(DATA_W - 1)) st_n = RX_IDLE;
          else                              cnt_n = cnt_q + 1'b1;
        end
      end
      default: st_n = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      frame   <= '0;
      go_exec <= 1'b0;
      go_read <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      frame   <= frame_n;
      go_exec <= go_exec_n;
      go_read <= go_read_n;
    end
  end

  // R10: a reply window never launches a command
  a_r10_quiet_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_REPLY) |=> (!go_exec && !go_read));

  // R1: a command is only launched for a frame carrying this node's address
  a_r1_addr_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (go_exec || go_read) |-> (frame.addr == node_addr));
endmodule

// File: rtl/bsn_regfile.sv
module bsn_regfile #(
  parameter int N_REG  = 16,
  parameter int WIDTH  = 8,
  localparam int IW    = $clog2(N_REG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IW-1:0]    ra,
  input  logic [IW-1:0]    rb,
  output logic [WIDTH-1:0] rdata_a,
  output logic [WIDTH-1:0] rdata_b
);
  logic [WIDTH-1:0] regs [N_REG];

  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    logic wen;
    assign wen = we && (waddr == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[i] <= '0;
      else if (wen) regs[i] <= wdata;
    end
  end

  assign rdata_a = regs[ra];
  assign rdata_b = regs[rb];
endmodule

// File: rtl/bsn_serial_alu.sv
module bsn_serial_alu
  import bsn_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int IW    = 4,
  localparam int CW   = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OP_W-1:0]  op,
  input  logic [IW-1:0]    dst,
  input  logic [WIDTH-1:0] a_opnd,
  input  logic [WIDTH-1:0] b_opnd,
  output logic             we,
  output logic [IW-1:0]    waddr,
  output logic [WIDTH-1:0] wdata,
  output logic             carry_flag
);
  logic             run_q, run_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             link_q, link_n;
  logic [WIDTH-2:0] acc_q, acc_n;
  logic [OP_W-1:0]  op_q, op_n;
  logic [IW-1:0]    dst_n;
  logic             cflag_n;
  logic [WIDTH-1:0] a_sh, b_sh;
  logic             ak, anx, bk, last, bit_o;

  assign a_sh  = a_opnd >> cnt_q;
  assign b_sh  = b_opnd >> cnt_q;
  assign ak    = a_sh[0];
  assign anx   = a_sh[1];
  assign bk    = b_sh[0];
  assign last  = (cnt_q == CW'(WIDTH - 1));
  assign we    = run_q && last;
  assign wdata = {bit_o, acc_q};

  // one result bit per cycle, LSB first; link_q is carry or held bit
  always_comb begin
    bit_o  = ak;
    link_n = link_q;
    unique case (op_q)
      OP_ADD: begin
        bit_o  = ak ^ bk ^ link_q;
        link_n = (ak & bk) | (link_q & (ak ^ bk));
      end
      OP_SLL: begin
        bit_o  = link_q;
        link_n = ak;
      end
      OP_SRL: bit_o = anx;
      OP_SRA: bit_o = last ? ak : anx;
      OP_ROR: begin
        bit_o  = last ? link_q : anx;
        link_n = (cnt_q == '0) ? ak : link_q;
      end
      OP_AND: bit_o = ak & bk;
      OP_OR:  bit_o = ak | bk;
      OP_XOR: bit_o = ak ^ bk;
      OP_NOT: bit_o = ~ak;
      default: bit_o = ak;
    endcase
  end

  always_comb begin
    run_n   = run_q;
    cnt_n   = cnt_q;
    acc_n   = acc_q;
    op_n    = op_q;
    dst_n   = waddr;
    cflag_n = carry_flag;
    if (start) begin
      run_n = 1'b1;
      cnt_n = '0;
      op_n  = op;
      dst_n = dst;
    end else if (run_q) begin
      acc_n = {bit_o, acc_q[WIDTH-2:1]};
      cnt_n = cnt_q + 1'b1;
      if (last) begin
        run_n = 1'b0;
        if (op_q == OP_ADD) cflag_n = link_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      cnt_q      <= '0;
      link_q     <= 1'b0;
      acc_q      <= '0;
      op_q       <= '0;
      waddr      <= '0;
      carry_flag <= 1'b0;
    end else begin
      run_q      <= run_n;
      cnt_q      <= cnt_n;
      link_q     <= start ? 1'b0 : (run_q ? link_n : link_q);
      acc_q      <= acc_n;
      op_q       <= op_n;
      waddr      <= dst_n;
      carry_flag <= cflag_n;
    end
  end

  // R12: a new command never arrives while one is still streaming
  a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !run_q);

  // R8: the carry flag only moves at the end of an add
  a_r8_cflag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (we && op_q != OP_ADD) |=> $stable(carry_flag));

  // R3: each operation writes exactly once, WIDTH cycles after launch
  a_r3_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !run_q);
endmodule

// File: rtl/bsn_tx.sv
module bsn_tx #(
  parameter int WIDTH = 8,
  localparam int CW   = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] data,
  input  logic             bit_edge,
  output logic             dat_o,
  output logic             oe
);
  logic [WIDTH-1:0] sh_q, sh_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             oe_n;

  assign dat_o = sh_q[0];

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    oe_n  = oe;
    if (load) begin
      sh_n  = data;
      cnt_n = '0;
      oe_n  = 1'b1;
    end else if (oe && bit_edge) begin
      if (cnt_q == CW'(WIDTH - 1)) begin
        oe_n = 1'b0;
        sh_n = '0;
      end else begin
        sh_n  = sh_q >> 1;
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      oe    <= 1'b0;
    end else begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
      oe    <= oe_n;
    end
  end

  // R7: bit 0 goes on the wire as soon as a reply is loaded
  a_r7_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (oe && dat_o == $past(data[0])));

  // R7: the wire is released after the last bit period
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && bit_edge && !load && cnt_q == CW'(WIDTH - 1)) |=> !oe);
endmodule

// File: rtl/bsn_node.sv
module bsn_node
  import bsn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] node_addr,
  input  logic              bus_clk_i,
  input  logic              bus_dat_i,
  output logic              bus_dat_o,
  output logic              bus_dat_oe
);
  logic [1:0]        rst_q;
  logic              rst_core_n;
  frame_t            frame;
  logic              go_exec, go_read, bit_edge;
  logic              alu_we, carry_flag;
  logic [IDX_W-1:0]  alu_waddr;
  logic [DATA_W-1:0] alu_wdata, rf_a, rf_b, a_opnd, reply;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_core_n = rst_q[1];

  bsn_rx i_rx (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bus_clk_i (bus_clk_i),
    .bus_dat_i (bus_dat_i),
    .node_addr (node_addr),
    .exec_done (alu_we),
    .frame     (frame),
    .go_exec   (go_exec),
    .go_read   (go_read),
    .bit_edge  (bit_edge)
  );

  bsn_regfile #(.N_REG(NREG), .WIDTH(DATA_W)) i_rf (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .we      (alu_we),
    .waddr   (alu_waddr),
    .wdata   (alu_wdata),
    .ra      (frame.src_a),
    .rb      (frame.src_b),
    .rdata_a (rf_a),
    .rdata_b (rf_b)
  );

  assign a_opnd = (frame.op == OP_LDI) ? {frame.src_b, frame.src_a} : rf_a;
  assign reply  = (frame.op == OP_RDST) ? {{(DATA_W-1){1'b0}}, carry_flag} : rf_a;

  bsn_serial_alu #(.WIDTH(DATA_W), .IW(IDX_W)) i_alu (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start      (go_exec),
    .op         (frame.op),
    .dst        (frame.dst),
    .a_opnd     (a_opnd),
    .b_opnd     (rf_b),
    .we         (alu_we),
    .waddr      (alu_waddr),
    .wdata      (alu_wdata),
    .carry_flag (carry_flag)
  );

  bsn_tx #(.WIDTH(DATA_W)) i_tx (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (go_read),
    .data     (reply),
    .bit_edge (bit_edge),
    .dat_o    (bus_dat_o),
    .oe       (bus_dat_oe)
  );

  // R9: opcodes 12..15 never reach the register file
  a_r9_no_illegal_write: assert property (@(posedge clk) disable iff (!rst_core_n)
    alu_we |-> (frame.op <= OP_NOT || frame.op == OP_LDI));
endmodule

// File: tb/test_bsn_node.sv
module test_bsn_node;
  localparam logic [7:0] MY    = 8'hA5;
  localparam logic [7:0] OTHER = 8'h5A;

  logic       clk, rst_n, bus_clk, tb_sd, dat_o, oe, bus_w;
  logic [7:0] mdl [16];
  logic       cm;
  int         n_run, n_fail;
  bit         finished;

  assign bus_w = oe ? dat_o : tb_sd;

  bsn_node i_bsn_node (
    .clk        (clk),
    .rst_n      (rst_n),
    .node_addr  (MY),
    .bus_clk_i  (bus_clk),
    .bus_dat_i  (bus_w),
    .bus_dat_o  (dat_o),
    .bus_dat_oe (oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_bit(input logic b);
    bus_clk = 1'b0; tb_sd = b; #32;
    bus_clk = 1'b1; #32;
  endtask

  task automatic send(input logic [7:0] a, input logic [3:0] op, input logic [3:0] d,
                      input logic [3:0] sa, input logic [3:0] sb);
    logic [23:0] f;
    f = {sb, sa, d, op, a};
    bus_bit(1'b0);
    for (int i = 0; i < 24; i++) bus_bit(f[i]);
    tb_sd = 1'b1;
  endtask

  // collect 8 reply bits; count bit periods where enable was missing
  task automatic collect(output logic [7:0] v, output int miss);
    v = '0; miss = 0;
    for (int i = 0; i < 8; i++) begin
      bus_clk = 1'b0; tb_sd = 1'b1; #16;
      v[i] = bus_w;
      if (!oe) miss++;
      #16; bus_clk = 1'b1; #32;
    end
    bus_clk = 1'b0; #24;
  endtask

  task automatic read_chk(input string req, input logic [3:0] idx, input logic [7:0] exp);
    logic [7:0] v; int miss;
    send(MY, 4'd9, 4'd0, idx, 4'd0);
    collect(v, miss);
    chk({req, " enable held"}, miss, 0);
    chk({req, " value"}, v, exp);
    chk({req, " released"}, oe, 0);
  endtask

  task automatic run_op(input string req, input logic [3:0] op, input logic [3:0] d,
                        input logic [3:0] sa, input logic [3:0] sb);
    logic [7:0] a, b, r;
    a = mdl[sa]; b = mdl[sb]; r = mdl[d];
    case (op)
      4'd0: {cm, r} = {1'b0, a} + {1'b0, b};
      4'd1: r = {a[6:0], 1'b0};
      4'd2: r = {1'b0, a[7:1]};
      4'd3: r = {a[7], a[7:1]};
      4'd4: r = {a[0], a[7:1]};
      4'd5: r = a & b;
      4'd6: r = a | b;
      4'd7: r = a ^ b;
      4'd8: r = ~a;
      4'd11: r = {sb, sa};
      default: r = mdl[d];
    endcase
    mdl[d] = r;
    send(MY, op, d, sa, sb);
    read_chk(req, d, mdl[d]);
  endtask

  task automatic t_reset;
    chk("R11 enable after reset", oe, 0);
    read_chk("R11 r0", 4'd0, 8'h00);
    read_chk("R11 r15", 4'd15, 8'h00);
    send(MY, 4'd10, 0, 0, 0);
    begin
      logic [7:0] v; int m;
      collect(v, m);
      chk("R11 carry", v, 0);
    end
  endtask

  task automatic t_load;
    run_op("R2 R9 ldi r1", 4'd11, 4'd1, 4'hA, 4'h5);
    run_op("R9 ldi r2", 4'd11, 4'd2, 4'hC, 4'h3);
    run_op("R9 ldi r3", 4'd11, 4'd3, 4'h1, 4'h8);
    run_op("R9 ldi r4", 4'd11, 4'd4, 4'h0, 4'hF);
    run_op("R9 ldi r5", 4'd11, 4'd5, 4'h0, 4'h2);
  endtask

  task automatic t_add;
    logic [7:0] v; int m;
    run_op("R3 add nc", 4'd0, 4'd6, 4'd1, 4'd2);
    send(MY, 4'd10, 0, 0, 0); collect(v, m);
    chk("R3 R8 carry 0", v, {7'b0, cm});
    run_op("R3 add c", 4'd0, 4'd7, 4'd4, 4'd5);
    send(MY, 4'd10, 0, 0, 0); collect(v, m);
    chk("R3 R8 carry 1", v, 1);
    run_op("R8 not keeps carry", 4'd8, 4'd8, 4'd1, 4'd0);
    send(MY, 4'd10, 0, 0, 0); collect(v, m);
    chk("R8 carry kept", v, 1);
    run_op("R3 add clears carry", 4'd0, 4'd9, 4'd1, 4'd1);
    send(MY, 4'd10, 0, 0, 0); collect(v, m);
    chk("R3 carry cleared", v, {7'b0, cm});
  endtask

  task automatic t_shift;
    run_op("R4 sll", 4'd1, 4'd10, 4'd3, 4'd0);
    run_op("R4 srl", 4'd2, 4'd10, 4'd3, 4'd0);
    run_op("R5 sra neg", 4'd3, 4'd10, 4'd3, 4'd0);
    run_op("R5 ror", 4'd4, 4'd10, 4'd3, 4'd0);
    run_op("R5 sra pos", 4'd3, 4'd10, 4'd1, 4'd0);
    run_op("R9 ldi one", 4'd11, 4'd11, 4'd1, 4'd0);
    run_op("R5 ror wrap", 4'd4, 4'd11, 4'd11, 4'd0);
    run_op("R4 sll msb lost", 4'd1, 4'd11, 4'd11, 4'd0);
  endtask

  task automatic t_logic;
    run_op("R6 and", 4'd5, 4'd12, 4'd1, 4'd2);
    run_op("R6 or", 4'd6, 4'd12, 4'd1, 4'd2);
    run_op("R6 xor", 4'd7, 4'd12, 4'd1, 4'd2);
    run_op("R6 not", 4'd8, 4'd12, 4'd2, 4'd0);
  endtask

  task automatic t_mismatch;
    logic [7:0] v; int m;
    send(OTHER, 4'd11, 4'd1, 4'h3, 4'h3);
    read_chk("R1 foreign write", 4'd1, mdl[1]);
    // foreign read: emulate the other node replying with zeros
    send(OTHER, 4'd9, 4'd0, 4'd1, 4'd0);
    m = 0;
    for (int i = 0; i < 8; i++) begin
      bus_clk = 1'b0; tb_sd = 1'b0; #16;
      if (oe) m++;
      #16; bus_clk = 1'b1; #32;
    end
    tb_sd = 1'b1;
    chk("R1 no drive on foreign read", m, 0);
    read_chk("R10 sync after foreign reply", 4'd2, mdl[2]);
    v = 0;
  endtask

  task automatic t_illegal;
    int m;
    send(MY, 4'd13, 4'd1, 4'd2, 4'd2);
    m = 0;
    for (int i = 0; i < 8; i++) begin
      bus_clk = 1'b0; #16;
      if (oe) m++;
      #16; bus_clk = 1'b1; #32;
    end
    chk("R9 illegal no drive", m, 0);
    read_chk("R9 illegal no write", 4'd1, mdl[1]);
  endtask

  task automatic t_back2back;
    logic [3:0] op;
    op = 4'd0;
    send(MY, op, 4'd1, 4'd1, 4'd1);
    {cm, mdl[1]} = {1'b0, mdl[1]} + {1'b0, mdl[1]};
    read_chk("R12 in-place add then read", 4'd1, mdl[1]);
  endtask

  initial begin
    n_run = 0; n_fail = 0; finished = 0;
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    cm = 1'b0;
    bus_clk = 1'b0; tb_sd = 1'b1; rst_n = 1'b0;
    #40 rst_n = 1'b1;
    #40;
    t_reset;
    t_load;
    t_add;
    t_shift;
    t_logic;
    t_mismatch;
    t_illegal;
    t_back2back;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule